// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block takes an incoming clock and hands out a slower copy of it, at the full rate or at one half, one quarter or one eighth of it. Two select pins choose the ratio. The divider stages step on the falling edge of the incoming clock. At the fastest setting the incoming clock passes straight to the output with no stage in the path.

An active-low master reset overrides everything else. While it is low, the divider is cleared at once, the output-enable flag drops so that a pad would float the output, and the run-enable that keeps an upstream oscillator going is withdrawn. Each control pin has a weak pull-up. This is modelled as a level input paired with a drive flag, and an undriven pin reads high. Left undriven, the selects therefore give the slowest ratio and the reset stays inactive.

Top module: `clkDivTop`

## Requirements
- R1: The effective select value n (S2 as bit 1, S1 as bit 0) sets a ratio of 2^n. 00 gives /1, 01 gives /2, 10 gives /4 and 11 gives /8. For n greater than zero, the output equals bit n-1 of a counter that advances by one on each counted edge.
- R2: With an effective select of 00 and reset inactive, `clkOut` equals `clkIn` in both clock phases.
- R3: Counting happens on the falling edge of `clkIn`. After reset is released, `clkOut` is low until the first falling edge. That first falling edge is counted, so at ratio /2 the output is high straight after it.
- R4: A select pin whose drive flag is 0 reads as 1, whatever its level input. With both selects undriven, the ratio is /8.
- R5: A reset pin whose drive flag is 0 reads as inactive (high). The block then runs normally with `outEnable` and `oscRun` high.
- R6: An effective reset low clears the divider asynchronously, without waiting for a clock edge, and holds `clkOut` low, whatever the selects are.
- R7: `outEnable` is low exactly while the effective reset is low.
- R8: `oscRun` is low exactly while the effective reset is low.
- R9: From a reset release, a window of 16 input periods gives `clkOut` a 50% duty cycle and exactly 16/ratio rising transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Incoming clock; the divider counts on its falling edge |
| selLevel | input | 2 | Level driven onto the select pins (bit 1 = S2, bit 0 = S1) |
| selDriven | input | 2 | Per-pin drive flag; 0 means the pin is left floating and pulled high |
| mrLevel | input | 1 | Level driven onto the active-low master reset pin |
| mrDriven | input | 1 | Drive flag for the reset pin; 0 means floating, read as inactive |
| clkOut | output | 1 | Divided clock, low while reset is held |
| outEnable | output | 1 | High when the output buffer drives; low means high impedance |
| oscRun | output | 1 | High while the clock source is allowed to run |

## Verification
A counter value that is wrong inside shows up at `clkOut` within at most 2^(n-1) falling edges, as a phase error, or within 2^n falling edges as a wrong period. A stale count left over from reset appears on the very first sample after release, because the output must start low. The bench models each pin's pull-up and the counter as plain integers, and compares every output half a phase after each clock edge. A wrong decode or a missing bypass is therefore flagged in the first phase it affects. A reset that is not asynchronous is caught one nanosecond after the reset falls, before any clock edge could hide it.

// File: rtl/clkdivPkg.sv
package clkdivPkg;

  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic clear;   // asynchronous clear of every divider stage
    logic runEn;   // clock source may run
    logic outEn;   // output buffer drives
  } divStrobes_t;

endpackage

// File: rtl/pinPullUp.sv
module pinPullUp #(
  parameter int WIDTH = 2
) (
  input  logic [WIDTH-1:0] pinLevel,
  input  logic [WIDTH-1:0] pinDriven,
  output logic [WIDTH-1:0] pinValue
);

  // Each pin: a floating pin is pulled to logic high
  for (genvar i = 0; i < WIDTH; i++) begin : gPin
    assign pinValue[i] = pinDriven[i] ? pinLevel[i] : 1'b1;
  end

endmodule

// File: rtl/divCtrl.sv
module divCtrl
  import clkdivPkg::*;
#(
  parameter int STAGES = 3,
  parameter int SEL_W  = $clog2(STAGES + 1)
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selValue,
  output divStrobes_t      strobes,
  output logic [SEL_W-1:0] tapIdx
);

  localparam logic [SEL_W-1:0] MaxTap = SEL_W'(STAGES);

  always_comb begin
    strobes.clear = ~rstN;
    strobes.runEn = rstN;
    strobes.outEn = rstN;
  end

  // Ratios beyond the chain length saturate at the last stage
  assign tapIdx = (selValue > MaxTap) ? MaxTap : selValue;

  always @(posedge clkIn) begin
    if (!rstN) begin
      AST_RUN_DROPPED: assert (!strobes.runEn && !strobes.outEn); // R8
    end
  end

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import clkdivPkg::*;
#(
  parameter int STAGES = 3,
  parameter int SEL_W  = $clog2(STAGES + 1)
) (
  input  logic             clkIn,
  input  divStrobes_t      strobes,
  input  logic [SEL_W-1:0] tapIdx,
  output logic             divOut
);

  logic              clearAsync;
  logic [STAGES-1:0] count;
  logic [STAGES:0]   taps;

  assign clearAsync = strobes.clear;

  // Falling-edge counter with asynchronous clear
  always_ff @(negedge clkIn or posedge clearAsync) begin
    if (clearAsync) count <= '0;
    else            count <= count + 1'b1;
  end

  // Tap 0 is the raw clock, tap k is counter bit k-1
  assign taps[0] = clkIn;
  for (genvar k = 0; k < STAGES; k++) begin : gTap
    assign taps[k+1] = count[k];
  end

  assign divOut = strobes.outEn & taps[tapIdx];

  AST_COUNT_STEP: assert property (@(negedge clkIn) disable iff (clearAsync)
    !$past(clearAsync) |-> count == $past(count) + 1'b1) else $error("count step"); // R3

  AST_DIV2_TOGGLE: assert property (@(negedge clkIn) disable iff (clearAsync)
    (!$past(clearAsync) && tapIdx == SEL_W'(1) && $past(tapIdx) == SEL_W'(1))
      |-> divOut != $past(divOut)) else $error("div2 toggle"); // R1

  AST_DIV4_TOGGLE: assert property (@(negedge clkIn) disable iff (clearAsync)
    (!$past(clearAsync) && tapIdx == SEL_W'(2) && $past(tapIdx) == SEL_W'(2))
      |-> (divOut != $past(divOut)) == $past(count[0])) else $error("div4 toggle"); // R1

endmodule

// File: rtl/clkDivTop.sv
module clkDivTop
  import clkdivPkg::*;
#(
  parameter int STAGES = 3,
  parameter int SEL_W  = $clog2(STAGES + 1)
) (
  input  logic             clkIn,
  input  logic [SEL_W-1:0] selLevel,
  input  logic [SEL_W-1:0] selDriven,
  input  logic             mrLevel,
  input  logic             mrDriven,
  output logic             clkOut,
  output logic             outEnable,
  output logic             oscRun
);

  logic [SEL_W-1:0] selValue;
  logic             mrValue;
  logic [SEL_W-1:0] tapIdx;
  divStrobes_t      strobes;

  pinPullUp #(.WIDTH(SEL_W)) u_selPins (
    .pinLevel (selLevel),
    .pinDriven(selDriven),
    .pinValue (selValue)
  );

  pinPullUp #(.WIDTH(1)) u_mrPin (
    .pinLevel (mrLevel),
    .pinDriven(mrDriven),
    .pinValue (mrValue)
  );

  divCtrl #(.STAGES(STAGES), .SEL_W(SEL_W)) u_ctrl (
    .clkIn   (clkIn),
    .rstN    (mrValue),
    .selValue(selValue),
    .strobes (strobes),
    .tapIdx  (tapIdx)
  );

  divDatapath #(.STAGES(STAGES), .SEL_W(SEL_W)) u_datapath (
    .clkIn  (clkIn),
    .strobes(strobes),
    .tapIdx (tapIdx),
    .divOut (clkOut)
  );

  assign outEnable = strobes.outEn;
  assign oscRun    = strobes.runEn;

  always @(posedge clkIn) begin
    if (!mrValue) begin
      AST_RESET_IDLE: assert (!clkOut); // R6
      AST_OUT_FLOATS: assert (!outEnable && !oscRun); // R7
    end
  end

endmodule

// File: tb/clkDivTop_bench.sv
module clkDivTop_bench;

  logic       clk = 1'b0;
  logic [1:0] selLevel;
  logic [1:0] selDriven;
  logic       mrLevel;
  logic       mrDriven;
  logic       clkOut, outEnable, oscRun;

  int checks = 0;
  int failures = 0;
  int refCount = 0;
  bit measuring = 0;
  int highs = 0;
  int rises = 0;
  logic prevS = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  clkDivTop u_clkDivTop (
    .clkIn    (clk),
    .selLevel (selLevel),
    .selDriven(selDriven),
    .mrLevel  (mrLevel),
    .mrDriven (mrDriven),
    .clkOut   (clkOut),
    .outEnable(outEnable),
    .oscRun   (oscRun)
  );

  // Pull-up model of the pins
  logic       mrEff;
  logic [1:0] selEff;
  assign mrEff     = mrDriven ? mrLevel : 1'b1;
  assign selEff[0] = selDriven[0] ? selLevel[0] : 1'b1;
  assign selEff[1] = selDriven[1] ? selLevel[1] : 1'b1;

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic checkInt(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural counter reference
  always @(negedge clk or negedge mrEff) begin
    if (!mrEff) refCount = 0;
    else        refCount = (refCount + 1) % 8;
  end

  // Compare every phase, 2 ns after each edge
  always @(clk) begin
    logic expOut;
    string tag;
    #2;
    if (!mrEff) begin
      expOut = 1'b0; tag = "R6";
    end else if (selEff == 2'b00) begin
      expOut = clk; tag = "R2";
    end else begin
      expOut = 1'(((refCount >> (int'(selEff) - 1)) & 1));
      tag = (selDriven == 2'b00) ? "R4" : "R1";
    end
    check(tag, clkOut, expOut);
    check(mrDriven ? "R7" : "R5", outEnable, mrEff);
    check(mrDriven ? "R8" : "R5", oscRun, mrEff);
    if (measuring) begin
      if (clkOut) highs++;
      if (clkOut && !prevS) rises++;
      prevS = clkOut;
    end
  end

  task automatic modeRun(input logic [1:0] lvl, input logic [1:0] drv, input int ratio);
    @(posedge clk); #1;
    mrDriven = 1'b1; mrLevel = 1'b0;
    selLevel = lvl; selDriven = drv;
    repeat (2) @(posedge clk);
    #1 mrLevel = 1'b1;
    #1;
    if (ratio > 1) check("R3 low before first fall", clkOut, 1'b0);
    #1;
    highs = 0; rises = 0; prevS = 1'b0; measuring = 1;
    if (ratio == 2) begin
      @(negedge clk); #2;
      check("R3 first fall counted", clkOut, 1'b1);
    end
    repeat (16) @(posedge clk);
    #3 measuring = 0;
    checkInt("R9 duty", highs, 16);
    checkInt("R9 period", rises, 16 / ratio);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mrDriven = 1'b1; mrLevel = 1'b0;
    selDriven = 2'b11; selLevel = 2'b01;
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset state", clkOut, 1'b0);
    check("R7 reset state", outEnable, 1'b0);
    check("R8 reset state", oscRun, 1'b0);

    modeRun(2'b01, 2'b11, 2);   // R1 /2
    modeRun(2'b00, 2'b11, 1);   // R2 bypass
    modeRun(2'b10, 2'b11, 4);   // R1 /4
    modeRun(2'b11, 2'b11, 8);   // R1 /8
    modeRun(2'b00, 2'b00, 8);   // R4 both floating -> /8
    modeRun(2'b00, 2'b01, 4);   // R4 S2 floating high, S1 low -> /4

    // R5: floating reset pin, level ignored
    @(posedge clk); #1;
    mrLevel = 1'b0; mrDriven = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    check("R5 floating reset inactive", outEnable, 1'b1);

    // R6: asynchronous clear in the high phase, /2 with output high
    selDriven = 2'b11; selLevel = 2'b01;
    mrDriven = 1'b1; mrLevel = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    @(posedge clk); #1;
    if (clkOut) begin
      mrLevel = 1'b0; #1;
      check("R6 async clear", clkOut, 1'b0);
      check("R7 async", outEnable, 1'b0);
      check("R8 async", oscRun, 1'b0);
    end else begin
      @(negedge clk); @(posedge clk); #1;
      mrLevel = 1'b0; #1;
      check("R6 async clear", clkOut, 1'b0);
      check("R7 async", outEnable, 1'b0);
      check("R8 async", oscRun, 1'b0);
    end
    // R6: reset overrides the bypass setting too
    selLevel = 2'b00; #1;
    check("R6 override bypass", clkOut, 1'b0);
    repeat (2) @(posedge clk);
    #1 mrLevel = 1'b1;

    // R1: select change on the fly, model follows the running count
    repeat (5) @(posedge clk);
    #1 selLevel = 2'b11;
    repeat (12) @(posedge clk);
    #1 selLevel = 2'b10;
    repeat (12) @(posedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule